// File: doc/BRIEF.md
# Infrared Pulse-Timing Capture Receiver

This block measures the timing of an already demodulated remote-control input. That input can come from an infrared receiver or a UHF receiver. For every symbol it records two values. The first is the time the carrier is present, called the mark. The second is the time from the start of that mark to the start of the next one, called the period. Software gets the space by subtracting the mark from the period. Each pair goes into an eight-entry queue, which software drains through a small register interface.

A programmable divisor slows the system clock down to a counting tick, and all durations are counted in ticks. The input can be inverted for an active-low pin. It is then synchronised and filtered before any edge is seen. A train of symbols ends when no new mark begins within a programmable maximum period. The final symbol of the train is then queued with the reserved period code 0xFFFF. An interrupt output combines four status causes, each with its own enable, and the causes are cleared by writing ones.

Top module: `irc_rx_capture`

Register offsets (16-bit data):

| Offset | Access | Meaning |
|---|---|---|
| 0x00 | read | period of the oldest entry (no side effect) |
| 0x04 | read | mark of the oldest entry; this read removes the entry |
| 0x08 | read/write | interrupt enable, bits 3:0 |
| 0x0C | read | interrupt status, bits 3:0 |
| 0x10 | write | interrupt clear, write one to clear |
| 0x14 | read/write | control: bit 0 capture enable, bit 1 invert input |
| 0x18 | read/write | maximum period in ticks (reset 0xFFFF) |
| 0x1C | read/write | tick divisor (reset 1, 0 acts as 1) |
| 0x20 | read | receive status |

## Requirements
- R1: One tick occurs every D system clocks, where D is the divisor at 0x1C (0 is treated as 1). All durations are counted in ticks.
- R2: An entry holds the mark in ticks (input active) and the period in ticks from one mark start to the next. The entry is queued when the next mark starts.
- R3: If a space runs until the period count reaches the maximum at 0x18, the entry is queued with period 0xFFFF. Interrupt status bit 1 (last symbol) is then set.
- R4: The mark and period counts saturate at 0xFFFE, so a real measurement never equals 0xFFFF.
- R5: A level change must be seen on 2 consecutive ticks to count. A 1-tick glitch has no effect on the queued entries.
- R6: Control bit 1 inverts the input, so a low pin is treated as carrier present.
- R7: With control bit 0 clear, no measurement runs and nothing is queued.
- R8: The queue holds 8 entries. Reading 0x00 returns the oldest period without removing it. Reading 0x04 returns the oldest mark and removes the entry. Both read 0 when the queue is empty.
- R9: A capture arriving while the queue is full is dropped and sets sticky status bit 2 (overrun). Bit 3 (full) becomes set and stays set while the queue is full.
- R10: Receive status at 0x20 gives the entry count in bits 15:8 and the overrun flag in bit 2. All other bits read 0.
- R11: Interrupt status bit 0 is 1 exactly when the queue is non-empty. Bits 1 to 3 are sticky and clear only when a one is written to the same bit of 0x10, so writing 0x4 clears only the overrun bit.
- R12: `irq` is high when any status bit is set together with its enable bit at 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ir_pin | input | 1 | demodulated receiver input |
| bus_wr | input | 1 | register write strobe |
| bus_rd | input | 1 | register read strobe (pops on 0x04) |
| bus_addr | input | 8 | register byte offset |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, combinational from bus_addr |
| irq | output | 1 | interrupt request |

## Verification
The assertions check, on every cycle, the following:
- the queue count never exceeds its depth;
- an accepted capture grows the count;
- a normal entry's mark never exceeds its period and never uses the end code;
- nothing is queued while disabled;
- the overrun flag stays set until cleared;
- `irq` never rises without a status cause.

Only the bench scenarios can show the rest. These are:
- that the measured tick counts match the pin waveform under different divisors and polarities;
- that a glitch is filtered out;
- that a train ends with 0xFFFF after the maximum period;
- that saturation holds over a 70,000-tick mark;
- that the ninth capture is lost while the first eight survive in order.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef logic [15:0] tick_t;

  localparam tick_t TICK_SAT = 16'hFFFE;
  localparam tick_t TICK_END = 16'hFFFF;

  typedef struct packed {
    tick_t mark;
    tick_t period;
  } capture_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MARK, ST_SPACE} meas_state_t;

  localparam int BIT_DATA = 0;
  localparam int BIT_LAST = 1;
  localparam int BIT_OVR  = 2;
  localparam int BIT_FULL = 3;

  localparam logic [7:0] A_PERIOD = 8'h00;
  localparam logic [7:0] A_MARK   = 8'h04;
  localparam logic [7:0] A_INTEN  = 8'h08;
  localparam logic [7:0] A_INTST  = 8'h0C;
  localparam logic [7:0] A_INTCLR = 8'h10;
  localparam logic [7:0] A_CTRL   = 8'h14;
  localparam logic [7:0] A_MAXPER = 8'h18;
  localparam logic [7:0] A_DIV    = 8'h1C;
  localparam logic [7:0] A_STATUS = 8'h20;

  function automatic tick_t sat_inc(tick_t v);
    return (v >= TICK_SAT) ? TICK_SAT : v + 16'd1;
  endfunction

  function automatic logic [15:0] eff_div(logic [15:0] d);
    return (d == 16'd0) ? 16'd1 : d;
  endfunction
endpackage

// File: rtl/irc_prescaler.sv
module irc_prescaler (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [15:0] div,
  output logic        tick
);
  import irc_pkg::*;
  logic [15:0] cnt_q;
  logic        at_end;

  assign at_end = (cnt_q >= eff_div(div) - 16'd1);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + 16'd1;
  end
endmodule

// File: rtl/irc_frontend.sv
module irc_frontend (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  input  logic tick,
  output logic rise,
  output logic fall
);
  logic [1:0] sync_q;
  logic       hist_q, filt_q, filt_n, lvl;

  assign lvl    = sync_q[1];
  assign filt_n = (tick && lvl == hist_q && lvl != filt_q) ? lvl : filt_q;
  assign rise   = !filt_q && filt_n;
  assign fall   = filt_q && !filt_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
      filt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin ^ invert};
      filt_q <= filt_n;
      if (tick) hist_q <= lvl;
    end
  end
endmodule

// File: rtl/irc_meas.sv
module irc_meas
  import irc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tick,
  input  logic     rise,
  input  logic     fall,
  input  tick_t    maxper,
  output logic     cap_push,
  output capture_t cap,
  output logic     cap_last
);
  meas_state_t st_q, st_n;
  tick_t       mark_q, mark_n, per_q, per_n;

  always_comb begin
    st_n     = st_q;
    mark_n   = mark_q;
    per_n    = per_q;
    cap_push = 1'b0;
    cap_last = 1'b0;
    cap      = '{mark: mark_q, period: sat_inc(per_q)};
    if (!en) begin
      st_n = ST_IDLE;
    end else if (tick) begin
      unique case (st_q)
        ST_IDLE: if (rise) begin
          st_n = ST_MARK; mark_n = '0; per_n = '0;
        end
        ST_MARK: begin
          per_n  = sat_inc(per_q);
          mark_n = sat_inc(mark_q);
          if (fall) st_n = ST_SPACE;
        end
        ST_SPACE: begin
          if (rise) begin
            cap_push = 1'b1;
            st_n = ST_MARK; mark_n = '0; per_n = '0;
          end else if (sat_inc(per_q) >= maxper) begin
            cap_push   = 1'b1;
            cap_last   = 1'b1;
            cap.period = TICK_END;
            st_n       = ST_IDLE;
          end else begin
            per_n = sat_inc(per_q);
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; mark_q <= '0; per_q <= '0;
    end else begin
      st_q <= st_n; mark_q <= mark_n; per_q <= per_n;
    end
  end
endmodule

// File: rtl/irc_fifo.sv
module irc_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) if (do_push) mem[wp_q] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; count <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/irc_rx_capture.sv
module irc_rx_capture
  import irc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_pin,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq
);
  logic        rx_en, rx_inv;
  logic [3:0]  int_en, int_stat, clr_bits;
  tick_t       maxper;
  logic [15:0] divisor;
  logic        st_last, st_ovr, st_full;

  logic        tick, rise, fall;
  logic        cap_push, cap_last, cap_drop, pop_req;
  capture_t    cap, head;
  tick_t       cap_mark, cap_period;
  logic [CW-1:0] fifo_count;
  logic        fifo_full, fifo_empty;

  assign cap_mark   = cap.mark;
  assign cap_period = cap.period;

  irc_prescaler u_pre (.clk, .rst_n, .run(rx_en), .div(divisor), .tick);
  irc_frontend  u_fe  (.clk, .rst_n, .pin(ir_pin), .invert(rx_inv), .tick, .rise, .fall);
  irc_meas      u_meas(.clk, .rst_n, .en(rx_en), .tick, .rise, .fall, .maxper,
                       .cap_push, .cap, .cap_last);
  irc_fifo #(.DEPTH(DEPTH), .W($bits(capture_t))) u_q (
    .clk, .rst_n, .push(cap_push), .din(cap), .pop(pop_req), .dout(head),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty));

  assign cap_drop = cap_push && fifo_full;
  assign pop_req  = bus_rd && bus_addr == A_MARK;
  assign clr_bits = (bus_wr && bus_addr == A_INTCLR) ? bus_wdata[3:0] : 4'b0;
  assign int_stat = {st_full, st_ovr, st_last, !fifo_empty};
  assign irq      = |(int_stat & int_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0; rx_inv <= 1'b0; int_en <= '0;
      maxper <= TICK_END; divisor <= 16'd1;
      st_last <= 1'b0; st_ovr <= 1'b0; st_full <= 1'b0;
    end else begin
      if (bus_wr) begin
        unique case (bus_addr)
          A_INTEN:  int_en  <= bus_wdata[3:0];
          A_CTRL:   {rx_inv, rx_en} <= bus_wdata[1:0];
          A_MAXPER: maxper  <= bus_wdata;
          A_DIV:    divisor <= bus_wdata;
          default: ;
        endcase
      end
      st_last <= (st_last & ~clr_bits[BIT_LAST]) | (cap_push & cap_last);
      st_ovr  <= (st_ovr  & ~clr_bits[BIT_OVR])  | cap_drop;
      st_full <= (st_full & ~clr_bits[BIT_FULL]) | fifo_full;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_PERIOD: bus_rdata = fifo_empty ? 16'd0 : head.period;
      A_MARK:   bus_rdata = fifo_empty ? 16'd0 : head.mark;
      A_INTEN:  bus_rdata = {12'd0, int_en};
      A_INTST:  bus_rdata = {12'd0, int_stat};
      A_CTRL:   bus_rdata = {14'd0, rx_inv, rx_en};
      A_MAXPER: bus_rdata = maxper;
      A_DIV:    bus_rdata = divisor;
      A_STATUS: bus_rdata = {8'(fifo_count), 5'd0, st_ovr, 2'd0};
      default:  bus_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/irc_rx_capture_chk.sv
module irc_rx_capture_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_push,
  input logic          cap_last,
  input logic [15:0]   cap_mark,
  input logic [15:0]   cap_period,
  input logic [CW-1:0] fifo_count,
  input logic          pop_req,
  input logic          st_last,
  input logic          st_ovr,
  input logic [3:0]    clr_bits,
  input logic [3:0]    int_stat,
  input logic          rx_en,
  input logic          irq
);
  // R8: occupancy bounded by depth
  assert_fifo_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R8: an accepted capture without a pop grows the queue by one
  assert_fifo_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_push && fifo_count < CW'(DEPTH) && !(pop_req && fifo_count != '0))
      |=> fifo_count == $past(fifo_count) + CW'(1));

  // R2: an ordinary entry has mark within period and never the end code
  assert_mark_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_push && !cap_last) |-> (cap_mark <= cap_period && cap_period != 16'hFFFF));

  // R3: an end-of-train capture raises the last-symbol status
  assert_last_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_push && cap_last) |=> st_last);

  // R4: mark count never reaches the end code
  assert_mark_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_push |-> cap_mark != 16'hFFFF);

  // R7: disabled receiver queues nothing
  assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !cap_push);

  // R9: overrun stays set until its clear bit is written
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr && !clr_bits[2]) |=> st_ovr);

  // R12: the interrupt needs a status cause
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_stat != 4'd0);
endmodule

bind irc_rx_capture irc_rx_capture_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cap_push(cap_push), .cap_last(cap_last),
  .cap_mark(cap_mark), .cap_period(cap_period), .fifo_count(fifo_count),
  .pop_req(pop_req), .st_last(st_last), .st_ovr(st_ovr), .clr_bits(clr_bits),
  .int_stat(int_stat), .rx_en(rx_en), .irq(irq));

// File: tb/irc_rx_capture_tb.sv
module irc_rx_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_pin = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic act_lvl = 1'b1;
  int em[$], ep[$];
  localparam int MAXP = 200;

  always #2 clk = ~clk;

  irc_rx_capture dut_i (.clk, .rst_n, .ir_pin, .bus_wr, .bus_rd, .bus_addr,
                        .bus_wdata, .bus_rdata, .irq);

  function automatic int exp_period(int m, int s, bit last);
    return last ? 16'hFFFF : m + s;
  endfunction

  function automatic int exp_status(int cnt, bit ovr);
    return (cnt << 8) | (ovr ? 4 : 0);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = int'(bus_rdata);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic hold(input logic lvl, input int cyc);
    ir_pin = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic train(input int n, input int dv);
    for (int i = 0; i < n; i++) begin
      int m = 3 + int'($urandom % 28);
      int s = 3 + int'($urandom % 28);
      em.push_back(m); ep.push_back(exp_period(m, s, i == n - 1));
      hold(act_lvl, m * dv);
      hold(!act_lvl, s * dv);
    end
    hold(!act_lvl, (MAXP + 12) * dv);
  endtask

  task automatic drain(input string req);
    int v;
    rd(8'h20, v);
    check(((v >> 8) & 8'hFF) == em.size(), {req, " R10 count"}, (v >> 8) & 8'hFF, em.size());
    while (em.size() > 0) begin
      int m = em.pop_front();
      int p = ep.pop_front();
      rd(8'h00, v); check(v == p, {req, " period"}, v, p);
      rd(8'h04, v); check(v == m, {req, " mark"}, v, m);
    end
  endtask

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // Reset state
    rd(8'h20, v); check(v == 0, "R10 reset status", v, 0);
    rd(8'h0C, v); check(v == 0, "R11 reset int status", v, 0);
    rd(8'h04, v); check(v == 0, "R8 empty mark read", v, 0);
    check(irq == 0, "R12 reset irq", irq, 0);

    // R2 R3: basic train at divisor 1
    wr(8'h1C, 16'd1); wr(8'h18, 16'(MAXP)); wr(8'h14, 16'h1);
    train(5, 1);
    rd(8'h0C, v); check(v == 4'b0011, "R3 R11 status after train", v, 4'b0011);
    wr(8'h08, 16'h1);
    @(negedge clk); check(irq == 1, "R12 irq on data", irq, 1);
    drain("R2");
    rd(8'h0C, v); check(v == 4'b0010, "R11 data bit follows empty", v, 4'b0010);
    check(irq == 0, "R12 irq drops", irq, 0);

    // R1: divisor 3
    wr(8'h10, 16'hF); wr(8'h1C, 16'd3);
    train(4, 3);
    drain("R1");

    // R5: 1-tick glitch in the space
    wr(8'h1C, 16'd1);
    em.push_back(12); ep.push_back(16'hFFFF);
    hold(1, 12); hold(0, 10); hold(1, 1); hold(0, MAXP + 20);
    drain("R5");

    // R6: inverted input
    wr(8'h14, 16'h2); ir_pin = 1; act_lvl = 0;
    repeat (6) @(negedge clk);
    wr(8'h14, 16'h3);
    train(3, 1);
    drain("R6");

    // R7: disabled, pulses ignored
    wr(8'h14, 16'h0); act_lvl = 1; ir_pin = 0;
    repeat (6) @(negedge clk);
    hold(1, 8); hold(0, 8); hold(1, 8); hold(0, 8);
    rd(8'h20, v); check(v == 0, "R7 nothing queued", v, 0);

    // R9 R10 R11 R12: overrun
    wr(8'h10, 16'hF); wr(8'h14, 16'h1);
    train(9, 1);
    void'(em.pop_back()); void'(ep.pop_back());
    rd(8'h20, v); check(v == exp_status(8, 1), "R9 R10 full+overrun status", v, exp_status(8, 1));
    rd(8'h0C, v); check(v == 4'hF, "R9 int status all set", v, 4'hF);
    wr(8'h08, 16'h4);
    @(negedge clk); check(irq == 1, "R12 irq on overrun", irq, 1);
    wr(8'h10, 16'h4);
    rd(8'h0C, v); check(v == 4'hB, "R11 clear only overrun", v, 4'hB);
    check(irq == 0, "R12 irq after clear", irq, 0);
    drain("R9");
    rd(8'h0C, v); check(v == 4'hA, "R9 full sticky", v, 4'hA);
    wr(8'h10, 16'hA);
    rd(8'h0C, v); check(v == 0, "R11 clear rest", v, 0);

    // R4: saturation
    wr(8'h18, 16'hFFFF);
    hold(1, 70000); hold(0, 10); hold(1, 5); hold(0, 20);
    em.push_back(16'hFFFE); ep.push_back(16'hFFFE);
    rd(8'h00, v); check(v == 16'hFFFE, "R4 period saturates", v, 16'hFFFE);
    rd(8'h04, v); check(v == 16'hFFFE, "R4 mark saturates", v, 16'hFFFE);
    em.delete(); ep.delete();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule